// File: doc/BRIEF.md
# Multiply Stall and Writeback Controller

This block sits beside a single-cycle integer datapath and lets it host a slow, iterative multiplier. Each cycle it looks at the instruction word the datapath is executing. When that word is a register-register multiply, it raises a stall in the same cycle, with no register in the path. The stall freezes the program counter and blocks the register-file write. In that same cycle it also sends one start pulse to the multiplier.

The controller then waits for the multiplier's done signal. In the cycle after done it drops the stall and raises a pending flag, which steers the writeback path to the multiplier result. It also forces exactly one register-file write. The program counter advances at the end of that cycle, so the next instruction only runs once the product has been written. Any other instruction passes straight through, and the datapath's own write enable reaches the register file unchanged.

Top module: `mul_stall_ctrl`

## Requirements
- R1: An instruction word is a multiply when bits [6:0] equal 7'b0110011 and bit 25 is 1. When an idle controller sees such a word, `stall_o` is high in that same cycle.
- R2: If done arrives L cycles after the start pulse, the stall stays high for exactly L+1 cycles: the decode cycle plus L waiting cycles. During that window the program counter holds the multiply's address. The next instruction is presented only in the cycle after the write cycle.
- R3: `mul_start_o` is a one-cycle pulse in the decode cycle only. It is not repeated while the same multiply waits or writes back.
- R4: While `stall_o` is high, `rf_we_o` is low.
- R5: In the cycle after done is seen, `stall_o` is low, and both `wb_pending_o` and `rf_we_o` are high. This lasts exactly one cycle, after which the controller is idle again.
- R6: For any word that is not a multiply, the outputs are as follows while idle: `stall_o`, `mul_start_o` and `wb_pending_o` are low, and `rf_we_o` equals `core_we_i`. This covers R-type words with bit 25 clear, and other opcodes even when bit 25 is set.
- R7: A done pulse that arrives while the controller is idle or writing back has no effect on any output.
- R8: While `rst` is high, all four outputs are low. A synchronous reset, including one in the middle of a wait, returns the controller to idle.
- R9: A multiply that directly follows a multiply starts a new full sequence, with its own start pulse, stall window and single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | ILEN (32) | Instruction word currently executing |
| core_we_i | input | 1 | Register-file write enable from the main decoder |
| mul_done_i | input | 1 | Multiplier finished, one-cycle pulse |
| stall_o | output | 1 | Hold program counter (combinational) |
| mul_start_o | output | 1 | One-cycle multiplier start |
| wb_pending_o | output | 1 | Writeback selects multiplier result this cycle |
| rf_we_o | output | 1 | Final register-file write enable |

## Verification
The assertions assume that the instruction word stays constant while the stall is high. They also assume that done comes only while the controller is waiting, never in the decode cycle itself. The bench keeps within these assumptions by fetching the word from its own program counter, which honours the stall. Its behavioural multiplier answers a fixed latency (1, 4 or 7) after the start pulse. The bench injects spurious done pulses only in idle cycles with a non-multiply word, or in the write cycle. It changes the latency only while reset is held.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {
    MSC_IDLE  = 2'd0,
    MSC_BUSY  = 2'd1,
    MSC_WRITE = 2'd2
  } msc_state_e;
endpackage

// File: rtl/msc_decode.sv
module msc_decode #(
  parameter int ILEN       = 32,
  parameter int OPC_W      = 7,
  parameter logic [OPC_W-1:0] MUL_OPC = 7'b0110011,
  parameter int SEL_BIT    = 25
) (
  input  logic [ILEN-1:0] instr_i,
  output logic            is_mul_o
);
  localparam int HI_W = ILEN - SEL_BIT - 1;
  localparam int MID_W = SEL_BIT - OPC_W;

  logic [OPC_W-1:0] opcode;
  logic             sel;
  logic             unused_fields;

  assign opcode = instr_i[OPC_W-1:0];
  assign sel    = instr_i[SEL_BIT];

  generate
    if (HI_W > 0) begin : g_hi
      assign unused_fields = ^{instr_i[ILEN-1:SEL_BIT+1], instr_i[SEL_BIT-1:OPC_W]};
    end else begin : g_nohi
      assign unused_fields = ^instr_i[SEL_BIT-1:OPC_W];
    end
  endgenerate

  assign is_mul_o = (opcode == MUL_OPC) && sel && (MID_W > 0);
endmodule

// File: rtl/msc_fsm.sv
module msc_fsm
  import msc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic is_mul_i,
  input  logic done_i,
  output logic stall_o,
  output logic start_o,
  output logic pend_o
);
  msc_state_e st, nxt;
  logic stall_raw, start_raw, pend_raw;

  always_ff @(posedge clk) begin
    if (rst) st <= MSC_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt       = st;
    stall_raw = 1'b0;
    start_raw = 1'b0;
    pend_raw  = 1'b0;
    case (st)
      MSC_IDLE: begin
        if (is_mul_i) begin
          stall_raw = 1'b1;
          start_raw = 1'b1;
          nxt       = MSC_BUSY;
        end
      end
      MSC_BUSY: begin
        stall_raw = 1'b1;
        if (done_i) nxt = MSC_WRITE;
      end
      MSC_WRITE: begin
        pend_raw = 1'b1;
        nxt      = MSC_IDLE;
      end
      default: nxt = MSC_IDLE;
    endcase
  end

  assign stall_o = stall_raw & ~rst;
  assign start_o = start_raw & ~rst;
  assign pend_o  = pend_raw  & ~rst;
endmodule

// File: rtl/msc_we_gate.sv
module msc_we_gate (
  input  logic rst,
  input  logic stall_i,
  input  logic pend_i,
  input  logic core_we_i,
  output logic rf_we_o
);
  always_comb begin
    if (rst)          rf_we_o = 1'b0;
    else if (pend_i)  rf_we_o = 1'b1;
    else if (stall_i) rf_we_o = 1'b0;
    else              rf_we_o = core_we_i;
  end
endmodule

// File: rtl/mul_stall_ctrl.sv
module mul_stall_ctrl #(
  parameter int ILEN    = 32,
  parameter int OPC_W   = 7,
  parameter logic [OPC_W-1:0] MUL_OPC = 7'b0110011,
  parameter int SEL_BIT = 25
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ILEN-1:0] instr_i,
  input  logic            core_we_i,
  input  logic            mul_done_i,
  output logic            stall_o,
  output logic            mul_start_o,
  output logic            wb_pending_o,
  output logic            rf_we_o
);
  logic is_mul;

  msc_decode #(
    .ILEN(ILEN), .OPC_W(OPC_W), .MUL_OPC(MUL_OPC), .SEL_BIT(SEL_BIT)
  ) u_dec (
    .instr_i (instr_i),
    .is_mul_o(is_mul)
  );

  msc_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .is_mul_i(is_mul),
    .done_i  (mul_done_i),
    .stall_o (stall_o),
    .start_o (mul_start_o),
    .pend_o  (wb_pending_o)
  );

  msc_we_gate u_we (
    .rst      (rst),
    .stall_i  (stall_o),
    .pend_i   (wb_pending_o),
    .core_we_i(core_we_i),
    .rf_we_o  (rf_we_o)
  );
endmodule

// File: rtl/mul_stall_ctrl_chk.sv
module mul_stall_ctrl_chk #(
  parameter int ILEN    = 32,
  parameter int OPC_W   = 7,
  parameter logic [OPC_W-1:0] MUL_OPC = 7'b0110011,
  parameter int SEL_BIT = 25
) (
  input logic            clk,
  input logic            rst,
  input logic [ILEN-1:0] instr_i,
  input logic            core_we_i,
  input logic            mul_done_i,
  input logic            stall_o,
  input logic            mul_start_o,
  input logic            wb_pending_o,
  input logic            rf_we_o
);
  logic word_mul;
  assign word_mul = (instr_i[OPC_W-1:0] == MUL_OPC) && instr_i[SEL_BIT];

  AST_MUL_STALLS: assert property (@(posedge clk) disable iff (rst)
    (word_mul && !wb_pending_o) |-> stall_o); // R1
  AST_START_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    mul_start_o |-> stall_o); // R3
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mul_start_o |=> !mul_start_o); // R3
  AST_NO_WE_STALLED: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> !rf_we_o); // R4
  AST_PEND_WRITES: assert property (@(posedge clk) disable iff (rst)
    wb_pending_o |-> (rf_we_o && !stall_o)); // R5
  AST_PEND_ONCE: assert property (@(posedge clk) disable iff (rst)
    wb_pending_o |=> !wb_pending_o); // R5
  AST_PEND_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_pending_o |-> $past(mul_done_i)); // R5
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!word_mul && !wb_pending_o) |-> (!stall_o && rf_we_o == core_we_i)); // R6
  always_comb begin
    if (rst) AST_RESET_QUIET: assert (!stall_o && !mul_start_o && !wb_pending_o && !rf_we_o); // R8
  end
endmodule

bind mul_stall_ctrl mul_stall_ctrl_chk #(
  .ILEN(ILEN), .OPC_W(OPC_W), .MUL_OPC(MUL_OPC), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .instr_i(instr_i), .core_we_i(core_we_i),
  .mul_done_i(mul_done_i), .stall_o(stall_o), .mul_start_o(mul_start_o),
  .wb_pending_o(wb_pending_o), .rf_we_o(rf_we_o)
);

// File: tb/mul_stall_ctrl_test.sv
module mul_stall_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] instr;
  logic        core_we, mul_done;
  logic        stall, start, pend, rf_we;

  mul_stall_ctrl uut (
    .clk(clk), .rst(rst), .instr_i(instr), .core_we_i(core_we),
    .mul_done_i(mul_done), .stall_o(stall), .mul_start_o(start),
    .wb_pending_o(pend), .rf_we_o(rf_we)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction
  function automatic logic ismul(input logic [31:0] w);
    return (w[6:0] == 7'b0110011) && w[25];
  endfunction

  logic [31:0] prog [16];
  logic        pwe  [16];
  logic [3:0]  pc;
  int          lat = 4;
  int          cnt;
  logic        inj = 1'b0;
  logic        inj_en = 1'b0;
  logic        running = 1'b0;

  assign instr    = prog[pc];
  assign core_we  = pwe[pc];
  assign mul_done = (cnt == 1) || inj;

  always @(posedge clk) begin
    if (rst) begin
      pc  <= 4'd0;
      cnt <= 0;
    end else begin
      if (!stall) pc <= pc + 4'd1;
      if (start) cnt <= lat;
      else if (cnt > 0) cnt <= cnt - 1;
    end
  end

  int vectors = 0, errors = 0;
  int mcyc = -1;
  logic prev_inj = 1'b0, prev_write = 1'b0, chk_next_pc = 1'b0;
  logic [3:0] start_pc, exp_next_pc;

  task automatic cmp(input logic act, input logic exp, input string tag, input string nm);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (pc=%0d mcyc=%0d)", tag, nm, act, exp, pc, mcyc);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      logic e_st, e_sa, e_pd, e_we;
      string tag;
      vectors++;
      if (chk_next_pc) begin
        // R2: next instruction presented only after the write cycle
        if (pc !== exp_next_pc) begin
          errors++;
          $display("FAIL R2 next pc: actual %0d expected %0d", pc, exp_next_pc);
        end
        chk_next_pc = 1'b0;
      end
      if (rst) begin
        e_st = 0; e_sa = 0; e_pd = 0; e_we = 0; tag = "R8";
        mcyc = -1;
      end else begin
        if (mcyc < 0 && ismul(instr)) begin
          mcyc = 0;
          start_pc = pc;
        end
        if (mcyc < 0) begin
          e_st = 0; e_sa = 0; e_pd = 0; e_we = core_we;
          tag = prev_inj ? "R7" : "R6";
        end else if (mcyc <= lat) begin
          e_st = 1; e_sa = (mcyc == 0); e_pd = 0; e_we = 0;
          tag = (mcyc == 0) ? (prev_write ? "R9" : "R1") : "R2";
          if (pc !== start_pc) begin
            errors++;
            $display("FAIL R2 pc hold: actual %0d expected %0d", pc, start_pc);
          end
        end else begin
          e_st = 0; e_sa = 0; e_pd = 1; e_we = 1; tag = "R5";
          if (pc !== start_pc) begin
            errors++;
            $display("FAIL R2 pc at write: actual %0d expected %0d", pc, start_pc);
          end
          chk_next_pc = 1'b1;
          exp_next_pc = start_pc + 4'd1;
        end
      end
      cmp(stall, e_st, tag, "stall");
      cmp(start, e_sa, (mcyc == 0) ? "R3" : tag, "start");
      cmp(pend,  e_pd, tag, "pending");
      cmp(rf_we, e_we, (e_st) ? "R4" : tag, "rf_we");
      prev_write = (!rst && mcyc == lat + 1);
      inj = inj_en && !rst && (mcyc < 0 || mcyc == lat + 1) && (vectors % 3 == 0);
      prev_inj = inj;
      if (!rst && mcyc >= 0) mcyc = (mcyc == lat + 1) ? -1 : mcyc + 1;
    end
  end

  task automatic cycles(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    prog[0]  = enc(7'b0000000, 3'd0, 7'b0010011); pwe[0]  = 1; // addi
    prog[1]  = enc(7'b0000001, 3'd0, 7'b0110011); pwe[1]  = 1; // mul
    prog[2]  = enc(7'b0000000, 3'd0, 7'b0010011); pwe[2]  = 1; // addi after mul
    prog[3]  = enc(7'b0100000, 3'd0, 7'b0110011); pwe[3]  = 1; // sub (bit25=0)
    prog[4]  = enc(7'b0000000, 3'd2, 7'b0100011); pwe[4]  = 0; // store
    prog[5]  = enc(7'b0000001, 3'd3, 7'b0110011); pwe[5]  = 1; // mulhu
    prog[6]  = enc(7'b0000001, 3'd1, 7'b0110011); pwe[6]  = 1; // mulh back-to-back
    prog[7]  = enc(7'b0000001, 3'd0, 7'b0010011); pwe[7]  = 1; // addi, bit25 set
    prog[8]  = enc(7'b0000001, 3'd2, 7'b0110011); pwe[8]  = 1; // mulhsu
    prog[9]  = enc(7'b0000000, 3'd6, 7'b0110011); pwe[9]  = 1; // or
    prog[10] = enc(7'b0000000, 3'd0, 7'b0010011); pwe[10] = 0;
    prog[11] = enc(7'b0000001, 3'd0, 7'b1100011); pwe[11] = 0; // branch, bit25 set
    prog[12] = enc(7'b0000001, 3'd0, 7'b0110011); pwe[12] = 1; // mul
    prog[13] = enc(7'b0000000, 3'd2, 7'b0000011); pwe[13] = 1; // load
    prog[14] = enc(7'b0000000, 3'd0, 7'b0010011); pwe[14] = 1;
    prog[15] = enc(7'b0000000, 3'd4, 7'b0010011); pwe[15] = 1;

    #2;
    running = 1'b1;
    cycles(3);
    rst = 1'b0;
    cycles(70);
    inj_en = 1'b1;                     // R7: spurious done pulses
    cycles(60);
    inj_en = 1'b0;
    while (mcyc != 2) cycles(1);       // R8: reset in the middle of a wait
    rst = 1'b1;
    cycles(1);
    rst = 1'b0;
    cycles(20);
    rst = 1'b1; lat = 1;
    cycles(2);
    rst = 1'b0;
    cycles(60);
    rst = 1'b1; lat = 7;
    cycles(2);
    rst = 1'b0;
    inj_en = 1'b1;
    cycles(120);
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule